// File: doc/BRIEF.md
# Activity-Switched GPIO Controller

This block drives 32 general-purpose pins for a radio front end. Each pin can switch its output value on its own as the radio moves between activity states: idle, receiving, transmitting, or both at once. It can also hold a fixed value written by software. The activity state comes from two status flags, `rx_busy` and `tx_busy`, which are synchronous to the block clock. For every pin, a per-bit static-mode bit decides whether the pin follows the activity state or holds its idle value.

Configuration arrives on a write-only settings bus. Each write carries a strobe, a byte address and a 32-bit word. Six word registers hold the configuration: four value banks indexed by activity state, a direction mask and a static-mode mask. A readback word shows the pin state. For output pins it returns the value being driven. For input pins it returns the pad level after a two-flop synchronizer.

Top module: `gpio_sw_top`

## Requirements
- R1: After reset, all six registers are zero, `pad_out` and `pad_oe` are all zero, and every pin is an input that follows the activity state.
- R2: For a bit whose static-mode bit is 0, `pad_out` takes that bit from one of four banks chosen by the flags. The idle bank (byte offset 0) is used when both flags are 0. The receive bank (offset 4) is used for `rx_busy`=1, `tx_busy`=0. The transmit bank (offset 8) is used for `rx_busy`=0, `tx_busy`=1. The duplex bank (offset 12) is used when both flags are 1.
- R3: For a bit whose static-mode bit is 1, `pad_out` drives that bit of the idle bank in every activity state.
- R4: The direction register at byte offset 16 sets `pad_oe`: a bit of 1 makes the pin an output and a bit of 0 makes it an input.
- R5: The static-mode register sits at byte offset 20.
- R6: Bit i of `pin_rdbk` equals `pad_out[i]` when the pin is an output. When the pin is an input, it equals `pad_in[i]` as sampled two clock edges earlier.
- R7: A change of `rx_busy`/`tx_busy` appears on `pad_out` at the first rising clock edge after the change. A register write appears on `pad_out`/`pad_oe` one edge after the write edge.
- R8: A write strobe to an address that is not word aligned, or that is at or above byte 24, changes no register. A write to a valid address replaces all 32 bits of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stb | input | 1 | Settings write strobe |
| cfg_addr | input | 8 | Settings byte address |
| cfg_data | input | 32 | Settings write word |
| rx_busy | input | 1 | Receive-active flag |
| tx_busy | input | 1 | Transmit-active flag |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Registered pad drive values |
| pad_oe | output | 32 | Registered per-pin output enables |
| pin_rdbk | output | 32 | Pin state readback |

## Verification
The bench gives the four banks distinct patterns, so that a swapped decode of the flag pair (receive and transmit banks crossed) shows up as a wrong word in exactly two of the four states. Mixed static-mode masks catch a design that applies the mask inverted or ignores it in the duplex state. Readback is sampled one cycle after a pad change as well as two cycles after, which exposes a synchronizer that is too short or too long. Writes to unaligned and out-of-range addresses carry all-ones data, so an address decode that aliases them onto a real register changes the pins visibly.

// File: rtl/gpio_sw_pkg.sv
package gpio_sw_pkg;

    localparam int unsigned PIN_W    = 32;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned NUM_REGS = 6;
    localparam int unsigned SYNC_STG = 2;

    // Byte offsets; word index = offset / 4
    localparam int unsigned OFS_IDLE = 0;
    localparam int unsigned OFS_RXO  = 4;
    localparam int unsigned OFS_TXO  = 8;
    localparam int unsigned OFS_FDX  = 12;
    localparam int unsigned OFS_DIR  = 16;
    localparam int unsigned OFS_STAT = 20;
    localparam int unsigned ADDR_END = NUM_REGS * 4;

    typedef logic [PIN_W-1:0] word_t;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'b00,
        ACT_RX   = 2'b01,
        ACT_TX   = 2'b10,
        ACT_FDX  = 2'b11
    } act_e;

    typedef struct packed {
        word_t idle;
        word_t rxo;
        word_t txo;
        word_t fdx;
        word_t dir;
        word_t stat;
    } cfg_t;

    function automatic act_e decode_act(input logic rx, input logic tx);
        return act_e'({tx, rx});
    endfunction

    function automatic word_t bank_word(input cfg_t c, input act_e a);
        word_t w;
        case (a)
            ACT_RX:  w = c.rxo;
            ACT_TX:  w = c.txo;
            ACT_FDX: w = c.fdx;
            default: w = c.idle;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/gpio_sw_regs.sv
module gpio_sw_regs
    import gpio_sw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             data,
    output cfg_t              cfg
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    word_t             bank [NUM_REGS];
    logic              hit;
    logic [IDX_W-1:0]  idx;

    assign idx = addr[ADDR_W-1:2];
    assign hit = stb && (addr[1:0] == 2'b00) && (32'(addr) < ADDR_END);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                bank[g] <= '0;
            else if (hit && (32'(idx) == g))
                bank[g] <= data;
        end
    end

    assign cfg.idle = bank[OFS_IDLE/4];
    assign cfg.rxo  = bank[OFS_RXO/4];
    assign cfg.txo  = bank[OFS_TXO/4];
    assign cfg.fdx  = bank[OFS_FDX/4];
    assign cfg.dir  = bank[OFS_DIR/4];
    assign cfg.stat = bank[OFS_STAT/4];
endmodule

// File: rtl/gpio_sw_sync.sv
module gpio_sw_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst)
            stg[0] <= '0;
        else
            stg[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stg
        always_ff @(posedge clk) begin
            if (rst)
                stg[s] <= '0;
            else
                stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_sw_drive.sv
module gpio_sw_drive
    import gpio_sw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cfg_t  cfg,
    input  logic  rx_busy,
    input  logic  tx_busy,
    output word_t pad_out,
    output word_t pad_oe
);
    act_e  act;
    word_t state_w;
    word_t sel_w;

    assign act     = decode_act(rx_busy, tx_busy);
    assign state_w = bank_word(cfg, act);

    for (genvar i = 0; i < PIN_W; i++) begin : g_bit
        assign sel_w[i] = cfg.stat[i] ? cfg.idle[i] : state_w[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pad_out <= '0;
            pad_oe  <= '0;
        end else begin
            pad_out <= sel_w;
            pad_oe  <= cfg.dir;
        end
    end
endmodule

// File: rtl/gpio_sw_top.sv
module gpio_sw_top
    import gpio_sw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_stb,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [PIN_W-1:0]  cfg_data,
    input  logic              rx_busy,
    input  logic              tx_busy,
    input  logic [PIN_W-1:0]  pad_in,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [PIN_W-1:0]  pin_rdbk
);
    cfg_t  cfg_q;
    word_t pad_sync;

    gpio_sw_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .stb  (cfg_stb),
        .addr (cfg_addr),
        .data (cfg_data),
        .cfg  (cfg_q)
    );

    gpio_sw_sync #(.W(PIN_W), .STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in),
        .dout (pad_sync)
    );

    gpio_sw_drive u_drive (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg_q),
        .rx_busy (rx_busy),
        .tx_busy (tx_busy),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign pin_rdbk = (pad_oe & pad_out) | (~pad_oe & pad_sync);
endmodule

// File: rtl/gpio_sw_chk.sv
module gpio_sw_chk
    import gpio_sw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_stb,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              rx_busy,
    input logic              tx_busy,
    input logic [PIN_W-1:0]  pad_out,
    input logic [PIN_W-1:0]  pad_oe,
    input cfg_t              cfg
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (pad_out == '0 && pad_oe == '0)); // R1

    AST_IDLE_PICK: assert property (@(posedge clk) disable iff (rst)
        (!rx_busy && !tx_busy) |=> pad_out == $past(cfg.idle)); // R2

    AST_FDX_PICK: assert property (@(posedge clk) disable iff (rst)
        (rx_busy && tx_busy) |=>
            ((pad_out ^ $past(cfg.fdx)) & ~$past(cfg.stat)) == '0); // R2

    AST_STATIC_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pad_out ^ $past(cfg.idle)) & $past(cfg.stat)) == '0); // R3

    AST_OE_DIR: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pad_oe == $past(cfg.dir)); // R4

    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cfg_stb && (cfg_addr[1:0] != 2'b00 || 32'(cfg_addr) >= ADDR_END))
            |=> $stable(cfg)); // R8
endmodule

bind gpio_sw_top gpio_sw_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_stb  (cfg_stb),
    .cfg_addr (cfg_addr),
    .rx_busy  (rx_busy),
    .tx_busy  (tx_busy),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .cfg      (cfg_q)
);

// File: tb/gpio_sw_top_tb_top.sv
module gpio_sw_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_stb = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_data = '0;
    logic        rx_busy = 1'b0;
    logic        tx_busy = 1'b0;
    logic [31:0] pad_in = 32'h1357_9BDF;
    logic [31:0] pad_out, pad_oe, pin_rdbk;

    always #5 clk = ~clk;

    gpio_sw_top dut_i (
        .clk(clk), .rst(rst), .cfg_stb(cfg_stb), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .rx_busy(rx_busy), .tx_busy(tx_busy),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_rdbk(pin_rdbk)
    );

    typedef struct {
        string       tag;
        logic [31:0] eo;
        logic [31:0] eoe;
        logic [31:0] er;
    } exp_t;

    exp_t  sb_q[$];
    event  ev_cmp;
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    logic [31:0] m_reg [6];

    function automatic logic [31:0] exp_out();
        logic [31:0] b;
        case ({tx_busy, rx_busy})
            2'b01:   b = m_reg[1];
            2'b10:   b = m_reg[2];
            2'b11:   b = m_reg[3];
            default: b = m_reg[0];
        endcase
        return (m_reg[5] & m_reg[0]) | (~m_reg[5] & b);
    endfunction

    task automatic push_raw(string tag, logic [31:0] eo, logic [31:0] eoe, logic [31:0] er);
        exp_t e;
        e.tag = tag; e.eo = eo; e.eoe = eoe; e.er = er;
        sb_q.push_back(e);
        -> ev_cmp;
        #1;
    endtask

    task automatic check(string tag);
        logic [31:0] eo;
        eo = exp_out();
        push_raw(tag, eo, m_reg[4], (m_reg[4] & eo) | (~m_reg[4] & pad_in));
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_stb = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_stb = 1'b0;
        if (a[1:0] == 2'b00 && a < 8'd24) m_reg[a[4:2]] = d;
    endtask

    task automatic set_act(logic r, logic t);
        rx_busy = r; tx_busy = t;
    endtask

    // monitor: pops expectations and compares against ports
    initial begin
        forever begin
            @(ev_cmp);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_run++;
                if (pad_out !== e.eo || pad_oe !== e.eoe || pin_rdbk !== e.er) begin
                    n_fail++;
                    $display("FAIL %s out=%h exp %h oe=%h exp %h rdbk=%h exp %h",
                             e.tag, pad_out, e.eo, pad_oe, e.eoe, pin_rdbk, e.er);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] old_o, old_p;
        for (int i = 0; i < 6; i++) m_reg[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        check("R1 reset state, all inputs");

        // distinct banks, all outputs, dynamic mode
        wr(8'd0,  32'hA5A5_A5A5);
        wr(8'd4,  32'h0F0F_0F0F);
        wr(8'd8,  32'h3C3C_3C3C);
        wr(8'd12, 32'hFFFF_0000);
        wr(8'd16, 32'hFFFF_FFFF);
        settle();
        check("R2 R4 idle bank");
        set_act(1, 0); settle(); check("R2 rx bank");
        set_act(0, 1); settle(); check("R2 tx bank");
        set_act(1, 1); settle(); check("R2 duplex bank");

        // mixed static mask
        wr(8'd20, 32'h00FF_00FF);
        for (int s = 0; s < 4; s++) begin
            set_act(s[0], s[1]); settle(); check("R3 R5 static mask sweep");
        end
        wr(8'd20, 32'hFFFF_FFFF);
        set_act(1, 1); settle(); check("R3 all static in duplex");
        wr(8'd20, 32'h0000_0000);

        // latency of activity change: exactly one edge
        set_act(0, 0); settle();
        @(negedge clk);
        old_o = exp_out();
        set_act(0, 1);
        push_raw("R7 before edge holds old", old_o, m_reg[4], old_o);
        @(negedge clk);
        check("R7 one edge after change");

        // mixed direction and readback
        wr(8'd16, 32'h0000_FFFF);
        pad_in = 32'hDEAD_BEEF;
        for (int s = 0; s < 4; s++) begin
            set_act(s[0], s[1]); settle(); check("R6 mixed direction readback");
        end

        // synchronizer depth
        @(negedge clk);
        old_p = pad_in;
        pad_in = 32'h1234_5678;
        @(negedge clk);
        old_o = exp_out();
        push_raw("R6 one edge after pad change", old_o, m_reg[4],
                 (m_reg[4] & old_o) | (~m_reg[4] & old_p));
        @(negedge clk);
        check("R6 two edges after pad change");

        // unmapped and unaligned writes ignored
        set_act(1, 0);
        wr(8'd24, 32'hFFFF_FFFF);
        wr(8'd2,  32'hFFFF_FFFF);
        wr(8'd6,  32'hFFFF_FFFF);
        wr(8'd128, 32'hFFFF_FFFF);
        wr(8'd255, 32'hFFFF_FFFF);
        settle();
        check("R8 unmapped writes ignored");
        set_act(0, 0); settle(); check("R8 idle unchanged after unmapped");

        // full-word replace
        wr(8'd0, 32'h0000_0001);
        settle();
        check("R8 whole word replaced");
        wr(8'd16, 32'h8000_0001);
        settle();
        check("R4 R8 direction rewrite");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule